// File: doc/BRIEF.md
# Pinned Destination Status Tracker

This block keeps the pinning status of one in-flight instruction whose destination registers may be pinned. A pinned destination is one that several writes share, all on the same physical register. The block watches three kinds of event. A rename event records a destination slot, its physical register index and whether that physical register is pinned. A writeback event reports that a pinned destination has been written. A squash request comes either from the general squash path or from the load/store queue.

When the instruction is squashed after a pinned rename, the block undoes its pinned-write bookkeeping once, and only once. For every pinned destination slot it sends a one-cycle increment pulse that carries the physical register index, aimed at that register's pinned-write counter. It also sends a matching pulse to the writes-to-complete counter if the pinned writeback already happened. This puts the external counters back in a consistent state, so that a re-rename lands on the same physical register. The counters, rename map and scoreboard sit outside the block. An illegal flag transition is refused and latches a sticky error.

Top module: `pin_status_tracker`

## Requirements
- R1: After synchronous reset every flag output, the error output and all pulse outputs are 0.
- R2: A rename with `ren_pinned`=1 that is legal sets `pin_renamed` from the next cycle on. A rename with `ren_pinned`=0 leaves `pin_renamed` unchanged but still records the slot as not pinned.
- R3: A pinned rename while `pin_written` or `pin_sq_done` is set is refused: flags and the slot record stay unchanged and `err` rises the next cycle.
- R4: A writeback sets `pin_written` the next cycle only if `pin_renamed`=1 and `pin_sq_done`=0. Otherwise it sets `err` and leaves `pin_written` unchanged.
- R5: Any squash sets `squashed`. A squash with `sq_lsq`=1 also sets `squashed_lsq`. Both flags stay set until reset.
- R6: A squash while `pin_renamed`=1 and `pin_sq_done`=0 produces, in the next cycle only, `inc_pw_valid[s]`=1 for each slot s recorded as pinned. Slot s's physical index appears on `inc_preg` bits [s*PREG_W +: PREG_W]. The same squash sets `pin_sq_done`.
- R7: In that same pulse cycle, `inc_wtc_valid[s]` is 1 exactly for the pinned slots, and only if `pin_written` was set.
- R8: A squash while `pin_renamed`=0 or `pin_sq_done`=1 gives no pulses, leaves `pin_sq_done` unchanged and raises no error.
- R9: `err` stays at 1 until reset once it is set.
- R10: Events in the same cycle apply in the order rename, then writeback, then squash. A pinned rename, a writeback and a squash in one cycle therefore give both pulses for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename event for one destination slot |
| ren_slot | input | SLOT_W | Destination slot being renamed |
| ren_preg | input | PREG_W | Physical register index assigned |
| ren_pinned | input | 1 | The physical register is pinned |
| wb_valid | input | 1 | Pinned destination written back |
| sq_valid | input | 1 | Squash request |
| sq_lsq | input | 1 | Squash comes from the load/store queue |
| squashed | output | 1 | Instruction squashed |
| squashed_lsq | output | 1 | Squashed by the load/store queue |
| pin_renamed | output | 1 | Pinned destination renamed |
| pin_written | output | 1 | Pinned destination written |
| pin_sq_done | output | 1 | Squash undo already performed |
| err | output | 1 | Sticky illegal-transition error |
| inc_pw_valid | output | NUM_SLOTS | Pinned-write counter increment pulse per slot |
| inc_wtc_valid | output | NUM_SLOTS | Writes-to-complete increment pulse per slot |
| inc_preg | output | NUM_SLOTS*PREG_W | Physical index per slot during a pulse |

## Verification
A wrong slot record does not show at first. It surfaces on the cycle after the undoing squash, as a missing, extra or mis-indexed increment pulse. A wrong flag shows at the flag outputs one cycle after the event that set it. It can also show later, as a refused or wrongly accepted transition that raises `err`, or as a second undo. The reference model is compared against every output on every cycle, so each such divergence is caught in the first cycle it becomes visible.

// File: rtl/pin_track_pkg.sv
package pin_track_pkg;

    typedef struct packed {
        logic renamed;
        logic written;
        logic sq_done;
    } pin_flags_t;

    localparam pin_flags_t PIN_FLAGS_CLR = '{renamed: 1'b0, written: 1'b0, sq_done: 1'b0};

    // A pinned rename is legal before any writeback or undo
    function automatic logic pin_rename_ok(pin_flags_t f);
        return !f.written && !f.sq_done;
    endfunction

    // A pinned writeback needs a prior pinned rename and no undo yet
    function automatic logic pin_wb_ok(pin_flags_t f);
        return f.renamed && !f.sq_done;
    endfunction

    // Squash undo is due once, after a pinned rename
    function automatic logic pin_undo_due(pin_flags_t f);
        return f.renamed && !f.sq_done;
    endfunction

endpackage

// File: rtl/pin_flag_ctrl.sv
module pin_flag_ctrl
    import pin_track_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ren_valid,
    input  logic       ren_pinned,
    input  logic       wb_valid,
    input  logic       sq_valid,
    input  logic       sq_lsq,
    output pin_flags_t flags_q,
    output logic       squashed_q,
    output logic       squashed_lsq_q,
    output logic       err_q,
    output logic       ren_accept,
    output logic       undo,
    output logic       undo_wtc
);

    pin_flags_t flags_d;
    logic       err_d;

    // Ordering within a cycle: rename, writeback, squash
    always_comb begin
        pin_flags_t f;
        logic       e;
        f          = flags_q;
        e          = 1'b0;
        ren_accept = 1'b1;
        if (ren_valid && ren_pinned) begin
            if (pin_rename_ok(f)) begin
                f.renamed = 1'b1;
            end else begin
                e          = 1'b1;
                ren_accept = 1'b0;
            end
        end
        if (wb_valid) begin
            if (pin_wb_ok(f)) f.written = 1'b1;
            else              e         = 1'b1;
        end
        undo     = sq_valid && pin_undo_due(f);
        undo_wtc = f.written;
        if (undo) f.sq_done = 1'b1;
        flags_d = f;
        err_d   = err_q | e;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q        <= PIN_FLAGS_CLR;
            squashed_q     <= 1'b0;
            squashed_lsq_q <= 1'b0;
            err_q          <= 1'b0;
        end else begin
            flags_q        <= flags_d;
            err_q          <= err_d;
            squashed_q     <= squashed_q | sq_valid;
            squashed_lsq_q <= squashed_lsq_q | (sq_valid & sq_lsq);
        end
    end

endmodule

// File: rtl/pin_slot_table.sv
module pin_slot_table #(
    parameter int NUM_SLOTS = 4,
    parameter int PREG_W    = 7,
    parameter int SLOT_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ren_valid,
    input  logic                        ren_accept,
    input  logic [SLOT_W-1:0]           ren_slot,
    input  logic                        ren_pinned,
    input  logic [PREG_W-1:0]           ren_preg,
    output logic [NUM_SLOTS-1:0]        pin_nx,
    output logic [NUM_SLOTS*PREG_W-1:0] preg_nx
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic              pin_q;
        logic [PREG_W-1:0] preg_q;
        logic              hit;

        assign hit                          = ren_valid && ren_accept && (ren_slot == SLOT_W'(s));
        assign pin_nx[s]                    = hit ? ren_pinned : pin_q;
        assign preg_nx[s*PREG_W +: PREG_W]  = hit ? ren_preg   : preg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pin_q  <= 1'b0;
                preg_q <= '0;
            end else begin
                pin_q  <= pin_nx[s];
                preg_q <= preg_nx[s*PREG_W +: PREG_W];
            end
        end
    end

endmodule

// File: rtl/pin_squash_pulse.sv
module pin_squash_pulse #(
    parameter int NUM_SLOTS = 4,
    parameter int PREG_W    = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        undo,
    input  logic                        undo_wtc,
    input  logic [NUM_SLOTS-1:0]        pin_nx,
    input  logic [NUM_SLOTS*PREG_W-1:0] preg_nx,
    output logic [NUM_SLOTS-1:0]        pw_q,
    output logic [NUM_SLOTS-1:0]        wtc_q,
    output logic [NUM_SLOTS*PREG_W-1:0] preg_q
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_pulse
        logic pw_d;
        assign pw_d = undo & pin_nx[s];

        always_ff @(posedge clk) begin
            if (rst) begin
                pw_q[s]                    <= 1'b0;
                wtc_q[s]                   <= 1'b0;
                preg_q[s*PREG_W +: PREG_W] <= '0;
            end else begin
                pw_q[s]                    <= pw_d;
                wtc_q[s]                   <= pw_d & undo_wtc;
                preg_q[s*PREG_W +: PREG_W] <= pw_d ? preg_nx[s*PREG_W +: PREG_W] : '0;
            end
        end
    end

endmodule

// File: rtl/pin_status_tracker.sv
module pin_status_tracker
    import pin_track_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int PREG_W    = 7,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ren_valid,
    input  logic [SLOT_W-1:0]           ren_slot,
    input  logic [PREG_W-1:0]           ren_preg,
    input  logic                        ren_pinned,
    input  logic                        wb_valid,
    input  logic                        sq_valid,
    input  logic                        sq_lsq,
    output logic                        squashed,
    output logic                        squashed_lsq,
    output logic                        pin_renamed,
    output logic                        pin_written,
    output logic                        pin_sq_done,
    output logic                        err,
    output logic [NUM_SLOTS-1:0]        inc_pw_valid,
    output logic [NUM_SLOTS-1:0]        inc_wtc_valid,
    output logic [NUM_SLOTS*PREG_W-1:0] inc_preg
);

    pin_flags_t                  flags;
    logic                        ren_accept;
    logic                        undo;
    logic                        undo_wtc;
    logic [NUM_SLOTS-1:0]        pin_nx;
    logic [NUM_SLOTS*PREG_W-1:0] preg_nx;

    pin_flag_ctrl u_flags (
        .clk            (clk),
        .rst            (rst),
        .ren_valid      (ren_valid),
        .ren_pinned     (ren_pinned),
        .wb_valid       (wb_valid),
        .sq_valid       (sq_valid),
        .sq_lsq         (sq_lsq),
        .flags_q        (flags),
        .squashed_q     (squashed),
        .squashed_lsq_q (squashed_lsq),
        .err_q          (err),
        .ren_accept     (ren_accept),
        .undo           (undo),
        .undo_wtc       (undo_wtc)
    );

    pin_slot_table #(.NUM_SLOTS(NUM_SLOTS), .PREG_W(PREG_W), .SLOT_W(SLOT_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .ren_valid  (ren_valid),
        .ren_accept (ren_accept),
        .ren_slot   (ren_slot),
        .ren_pinned (ren_pinned),
        .ren_preg   (ren_preg),
        .pin_nx     (pin_nx),
        .preg_nx    (preg_nx)
    );

    pin_squash_pulse #(.NUM_SLOTS(NUM_SLOTS), .PREG_W(PREG_W)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .undo     (undo),
        .undo_wtc (undo_wtc),
        .pin_nx   (pin_nx),
        .preg_nx  (preg_nx),
        .pw_q     (inc_pw_valid),
        .wtc_q    (inc_wtc_valid),
        .preg_q   (inc_preg)
    );

    assign pin_renamed = flags.renamed;
    assign pin_written = flags.written;
    assign pin_sq_done = flags.sq_done;

endmodule

// File: rtl/pin_track_chk.sv
module pin_track_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int PREG_W    = 7
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        sq_valid,
    input logic                        squashed,
    input logic                        squashed_lsq,
    input logic                        pin_renamed,
    input logic                        pin_written,
    input logic                        pin_sq_done,
    input logic                        err,
    input logic [NUM_SLOTS-1:0]        inc_pw_valid,
    input logic [NUM_SLOTS-1:0]        inc_wtc_valid,
    input logic [NUM_SLOTS*PREG_W-1:0] inc_preg
);

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        (|inc_pw_valid) |=> !(|inc_pw_valid));

    p_pulse_marks_done_r6: assert property (@(posedge clk) disable iff (rst)
        (|inc_pw_valid) |-> pin_sq_done);

    p_wtc_within_pw_r7: assert property (@(posedge clk) disable iff (rst)
        (inc_wtc_valid & ~inc_pw_valid) == '0);

    p_wtc_needs_written_r7: assert property (@(posedge clk) disable iff (rst)
        (|inc_wtc_valid) |-> pin_written);

    p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
        pin_sq_done |=> pin_sq_done);

    p_written_needs_renamed_r4: assert property (@(posedge clk) disable iff (rst)
        pin_written |-> pin_renamed);

    p_lsq_implies_squash_r5: assert property (@(posedge clk) disable iff (rst)
        squashed_lsq |-> squashed);

    p_squash_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> squashed);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    p_no_index_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !(|inc_pw_valid) |-> (inc_preg == '0));

endmodule

bind pin_status_tracker pin_track_chk #(.NUM_SLOTS(NUM_SLOTS), .PREG_W(PREG_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sq_valid      (sq_valid),
    .squashed      (squashed),
    .squashed_lsq  (squashed_lsq),
    .pin_renamed   (pin_renamed),
    .pin_written   (pin_written),
    .pin_sq_done   (pin_sq_done),
    .err           (err),
    .inc_pw_valid  (inc_pw_valid),
    .inc_wtc_valid (inc_wtc_valid),
    .inc_preg      (inc_preg)
);

// File: tb/sim_pin_status_tracker.sv
module sim_pin_status_tracker;

    localparam int NS = 4;
    localparam int PW = 7;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ren_valid = 1'b0;
    logic [SW-1:0] ren_slot = '0;
    logic [PW-1:0] ren_preg = '0;
    logic          ren_pinned = 1'b0;
    logic          wb_valid = 1'b0;
    logic          sq_valid = 1'b0;
    logic          sq_lsq = 1'b0;
    logic          squashed, squashed_lsq, pin_renamed, pin_written, pin_sq_done, err;
    logic [NS-1:0]    inc_pw_valid, inc_wtc_valid;
    logic [NS*PW-1:0] inc_preg;

    int n_checks = 0;
    int n_fail   = 0;
    bit started  = 0;

    always #10 clk = ~clk;

    pin_status_tracker #(.NUM_SLOTS(NS), .PREG_W(PW)) u0 (.*);

    // Behavioural reference model
    bit m_ren, m_wr, m_done, m_sq, m_sql, m_err;
    bit m_pin [NS];
    int m_preg[NS];
    bit m_pw  [NS];
    bit m_wtc [NS];

    always @(posedge clk) begin
        started <= 1'b1;
        for (int s = 0; s < NS; s++) begin m_pw[s] = 0; m_wtc[s] = 0; end
        if (rst) begin
            m_ren = 0; m_wr = 0; m_done = 0; m_sq = 0; m_sql = 0; m_err = 0;
            for (int s = 0; s < NS; s++) begin m_pin[s] = 0; m_preg[s] = 0; end
        end else begin
            if (ren_valid) begin
                if (ren_pinned) begin
                    if (m_wr || m_done) m_err = 1;
                    else begin
                        m_ren = 1;
                        m_pin[ren_slot] = 1;
                        m_preg[ren_slot] = int'(ren_preg);
                    end
                end else begin
                    m_pin[ren_slot] = 0;
                    m_preg[ren_slot] = int'(ren_preg);
                end
            end
            if (wb_valid) begin
                if (m_ren && !m_done) m_wr = 1;
                else m_err = 1;
            end
            if (sq_valid) begin
                m_sq = 1;
                if (sq_lsq) m_sql = 1;
                if (m_ren && !m_done) begin
                    for (int s = 0; s < NS; s++) begin
                        m_pw[s]  = m_pin[s];
                        m_wtc[s] = m_pin[s] && m_wr;
                    end
                    m_done = 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            chk("R2 pin_renamed", int'(pin_renamed), int'(m_ren));
            chk("R4 pin_written", int'(pin_written), int'(m_wr));
            chk("R8 pin_sq_done", int'(pin_sq_done), int'(m_done));
            chk("R5 squashed", int'(squashed), int'(m_sq));
            chk("R5 squashed_lsq", int'(squashed_lsq), int'(m_sql));
            chk("R9 err", int'(err), int'(m_err));
            for (int s = 0; s < NS; s++) begin
                chk("R6 inc_pw_valid", int'(inc_pw_valid[s]), int'(m_pw[s]));
                chk("R7 inc_wtc_valid", int'(inc_wtc_valid[s]), int'(m_wtc[s]));
                if (m_pw[s])
                    chk("R6 inc_preg", int'(inc_preg[s*PW +: PW]), m_preg[s]);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
        ren_valid = 0; wb_valid = 0; sq_valid = 0; sq_lsq = 0; ren_pinned = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        step();
        step();
        rst = 0;
    endtask

    task automatic ren(input int slot, input int preg, input bit pinned);
        ren_valid = 1; ren_slot = SW'(slot); ren_preg = PW'(preg); ren_pinned = pinned;
    endtask

    initial begin
        #1;
        do_reset();
        // R1: reset state
        chk("R1 flags", int'({squashed, squashed_lsq, pin_renamed, pin_written, pin_sq_done, err}), 0);
        chk("R1 pulses", int'({inc_pw_valid, inc_wtc_valid}), 0);

        // R2/R4/R6/R7: renames, writeback, squash undo
        ren(0, 5, 0); step();
        chk("R2 unpinned", int'(pin_renamed), 0);
        ren(1, 9, 1); step();
        chk("R2 pinned", int'(pin_renamed), 1);
        ren(3, 20, 1); step();
        wb_valid = 1; step();
        chk("R4 written", int'(pin_written), 1);
        sq_valid = 1; step();
        chk("R6 pulse mask", int'(inc_pw_valid), 4'b1010);
        chk("R7 wtc mask", int'(inc_wtc_valid), 4'b1010);
        chk("R6 slot3 index", int'(inc_preg[3*PW +: PW]), 20);
        step();
        chk("R6 one cycle", int'(inc_pw_valid), 0);
        // R8: repeat squash gives nothing
        sq_valid = 1; step();
        chk("R8 no pulse", int'(inc_pw_valid), 0);
        chk("R8 no err", int'(err), 0);
        // R4/R9: writeback after undo is illegal
        wb_valid = 1; step();
        chk("R4 late wb err", int'(err), 1);
        step(); step();
        chk("R9 sticky", int'(err), 1);

        // R5/R7: LSQ squash without writeback
        do_reset();
        ren(2, 33, 1); step();
        sq_valid = 1; sq_lsq = 1; step();
        chk("R5 lsq flag", int'(squashed_lsq), 1);
        chk("R5 general flag", int'(squashed), 1);
        chk("R7 no wtc", int'(inc_wtc_valid), 0);
        chk("R6 slot2 pulse", int'(inc_pw_valid), 4'b0100);
        // R3: pinned rename after undo
        ren(0, 7, 1); step();
        chk("R3 err after done", int'(err), 1);

        // R4: writeback without rename
        do_reset();
        wb_valid = 1; step();
        chk("R4 wb no rename", int'({err, pin_written}), 2);

        // R8: squash with nothing pinned, then pinned rename still legal
        do_reset();
        sq_valid = 1; step();
        chk("R8 done stays", int'(pin_sq_done), 0);
        ren(1, 11, 1); step();
        chk("R8 rename ok", int'({err, pin_renamed}), 1);

        // R3: pinned rename after writeback
        do_reset();
        ren(0, 4, 1); step();
        wb_valid = 1; step();
        ren(2, 6, 1); step();
        chk("R3 err after wb", int'(err), 1);
        sq_valid = 1; step();
        chk("R3 slot not recorded", int'(inc_pw_valid), 4'b0001);

        // R10: same-cycle rename, writeback and squash
        do_reset();
        ren(3, 77, 1); wb_valid = 1; sq_valid = 1; step();
        chk("R10 pw", int'(inc_pw_valid), 4'b1000);
        chk("R10 wtc", int'(inc_wtc_valid), 4'b1000);
        chk("R10 index", int'(inc_preg[3*PW +: PW]), 77);
        chk("R10 err", int'(err), 0);

        step();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule